// File: doc/BRIEF.md
# Cache line clean controller

A small direct-mapped write-back data cache. It serves word loads and word stores and adds a third command, clean. A clean command takes a byte address and finds the aligned line that holds that byte. If that line is resident and dirty, the block writes the whole line to memory. The line then stays resident and becomes clean, so a later access to it still hits. A clean command on a clean line, or on a line that is not resident, completes at once and causes no memory traffic.

The block handles one request at a time. A load or store that hits answers in the next cycle. A miss first writes back the resident line in that set, but only if that line is dirty. It then fills the set with one whole-line read. A clean command ends with a one-cycle done pulse, whether or not a write-back took place. Every store accepted before a clean command has already been merged into the line, so those stores are part of the written data.

Top module: `line_clean_cache`

## Requirements
- R1: A load returns the 32-bit word selected by address bits [OFF_W-1:2]. The value is the most recent store to that word, or the memory contents if there has been no store. req_op encodings: 2'b00 load, 2'b01 store, 2'b1x clean.
- R2: A clean command on a resident dirty line makes exactly one memory write of the whole line. The write includes every store accepted before the clean command.
- R3: A clean command on a clean line, or on a line that is not resident, makes no memory access. It completes in the cycle after it is accepted.
- R4: After a write-back caused by a clean command, the line stays valid. A load to that line then hits with no memory access.
- R5: The line a command affects is the address with its low OFF_W bits cleared, for any byte offset. Every memory request carries zero in those bits.
- R6: A clean command never sets a dirty bit. After a clean, evicting that line causes no write-back.
- R7: A store hit marks the line dirty. A miss writes back the resident line first only if it is dirty, then performs exactly one whole-line read.
- R8: Hits answer in the cycle after acceptance. While a memory transfer is pending, req_ready stays low.
- R9: clean_done and rsp_valid are single-cycle pulses. Each request produces exactly one of them: clean_done for a clean command, rsp_valid for a load or store.
- R10: After reset, req_ready is high and rsp_valid, clean_done and mem_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 00 load, 01 store, 1x clean |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_W | Store word |
| rsp_valid | output | 1 | Load/store complete pulse |
| rsp_rdata | output | WORD_W | Load data |
| clean_done | output | 1 | Clean command complete pulse |
| mem_valid | output | 1 | Memory request present |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Line-aligned byte address |
| mem_wdata | output | LINE_BYTES*8 | Line written back |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_rdata | input | LINE_BYTES*8 | Line read from memory |

## Verification
A dirty bit that is wrongly set or wrongly left set shows up at the memory port. It causes an extra write, either on the clean command itself or on the next eviction of that set, and the bench counts that write against the write count it expects for each request. A dirty bit that is wrongly cleared, or line data that is stale, shows up as a missing write or as a written line that disagrees with the expected contents. A stale tag or valid bit shows up as a fill that should not happen, or as a wrong load word in the cycle after the request. Every request is checked for its exact memory traffic and its result, so a fault in the state is reported within the request that exposes it.

// File: rtl/line_clean_cache.sv
module line_clean_cache #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 4,
  parameter int WORD_W     = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [WORD_W-1:0]       rsp_rdata,
  output logic                    clean_done,
  output logic                    mem_valid,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  input  logic                    mem_ready,
  input  logic [LINE_BYTES*8-1:0] mem_rdata
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BSEL_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BSEL_W;
  localparam logic [1:0] OP_STORE = 2'b01;

  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL} st_t;

  st_t                st_q;
  logic [LINE_W-1:0]  data_q [SETS];
  logic [TAG_W-1:0]   tag_q  [SETS];
  logic [SETS-1:0]    vld_q, dirty_q;
  logic [1:0]         op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [WORD_W-1:0]  wdata_q;

  logic [ADDR_W-1:0]  cur_addr;
  logic [IDX_W-1:0]   idx;
  logic [TAG_W-1:0]   tag;
  logic [WSEL_W-1:0]  wsel;
  logic               hit, line_we;
  logic [LINE_W-1:0]  line_wdata;
  logic               unused_lsb;

  assign cur_addr   = (st_q == ST_IDLE) ? req_addr : addr_q;
  assign idx        = cur_addr[OFF_W +: IDX_W];
  assign tag        = cur_addr[ADDR_W-1 -: TAG_W];
  assign wsel       = cur_addr[BSEL_W +: WSEL_W];
  assign unused_lsb = ^cur_addr[BSEL_W-1:0];
  assign hit        = vld_q[idx] && (tag_q[idx] == tag);

  assign req_ready = (st_q == ST_IDLE);
  assign mem_valid = (st_q != ST_IDLE);
  assign mem_we    = (st_q == ST_WB);
  assign mem_wdata = data_q[idx];
  assign mem_addr  = (st_q == ST_WB) ? {tag_q[idx], idx, {OFF_W{1'b0}}}
                                     : {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  assign line_we = (st_q == ST_IDLE && req_valid && req_op == OP_STORE && hit) ||
                   (st_q == ST_FILL && mem_ready);

  always_comb begin
    line_wdata = (st_q == ST_FILL) ? mem_rdata : data_q[idx];
    if (st_q == ST_IDLE)
      line_wdata[wsel*WORD_W +: WORD_W] = req_wdata;
    else if (op_q == OP_STORE)
      line_wdata[wsel*WORD_W +: WORD_W] = wdata_q;
  end

  always_ff @(posedge clk) begin
    if (line_we) begin
      data_q[idx] <= line_wdata;
      tag_q[idx]  <= tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      vld_q      <= '0;
      dirty_q    <= '0;
      op_q       <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      clean_done <= 1'b0;
    end else begin
      rsp_valid  <= 1'b0;
      clean_done <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          op_q    <= req_op;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          if (req_op[1]) begin
            if (hit && dirty_q[idx]) st_q <= ST_WB;
            else                     clean_done <= 1'b1;
          end else if (hit) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= data_q[idx][wsel*WORD_W +: WORD_W];
            if (req_op == OP_STORE) dirty_q[idx] <= 1'b1;
          end else if (vld_q[idx] && dirty_q[idx]) begin
            st_q <= ST_WB;
          end else begin
            st_q <= ST_FILL;
          end
        end
        ST_WB: if (mem_ready) begin
          dirty_q[idx] <= 1'b0;
          if (op_q[1]) begin
            clean_done <= 1'b1;
            st_q       <= ST_IDLE;
          end else begin
            st_q <= ST_FILL;
          end
        end
        ST_FILL: if (mem_ready) begin
          vld_q[idx]   <= 1'b1;
          dirty_q[idx] <= (op_q == OP_STORE);
          rsp_valid    <= 1'b1;
          rsp_rdata    <= mem_rdata[wsel*WORD_W +: WORD_W];
          st_q         <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/line_clean_cache_chk.sv
module line_clean_cache_chk #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic              rsp_valid,
  input logic              clean_done,
  input logic              mem_valid,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  // R5
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

  // R2
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) && $stable(mem_addr)));

  // R3
  clean_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op[1]) |=> !(mem_valid && !mem_we));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clean_done |=> !clean_done);

  // R9
  rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && clean_done));

  // R8
  fill_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_we) |=> (req_ready && rsp_valid));
endmodule

bind line_clean_cache line_clean_cache_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (.*);

// File: tb/line_clean_cache_tb.sv
module line_clean_cache_tb;
  localparam int AW = 10;
  localparam int LB = 16;
  localparam int LW = LB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          clean_done;
  logic          mem_valid, mem_we;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_wdata, mem_rdata;
  logic          mem_ready = 1'b0;

  always #10 clk = ~clk;

  line_clean_cache #(.ADDR_W(AW), .LINE_BYTES(LB), .SETS(4), .WORD_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .clean_done(clean_done),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  logic [LW-1:0] bmem [64];
  logic [31:0]   arch [256];
  logic [3:0]    rtag [4];
  logic [3:0]    rvld, rdirty;
  int            wr_cnt, rd_cnt, compared, mismatched;
  logic [AW-1:0] last_waddr;
  logic [LW-1:0] last_wdata;

  assign mem_rdata = bmem[mem_addr[9:4]];

  always @(negedge clk) begin
    if (mem_ready) mem_ready <= 1'b0;
    else if (mem_valid) begin
      mem_ready <= 1'b1;
      if (mem_we) begin
        wr_cnt++;
        last_waddr = mem_addr;
        last_wdata = mem_wdata;
        bmem[mem_addr[9:4]] <= mem_wdata;
      end else rd_cnt++;
      if (mem_addr[3:0] != 4'd0) begin
        compared++; mismatched++;
        $display("FAIL R5 mem_addr offset actual=%0h expected=0", mem_addr[3:0]);
      end
    end
  end

  task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] arch_line(input logic [5:0] ln);
    return {arch[{ln, 2'd3}], arch[{ln, 2'd2}], arch[{ln, 2'd1}], arch[{ln, 2'd0}]};
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [31:0] d);
    logic [1:0] s;
    logic [3:0] t;
    logic hit, exp_w, exp_r;
    logic [AW-1:0] exp_waddr;
    int cyc;
    s = a[5:4]; t = a[9:6];
    hit = rvld[s] && rtag[s] == t;
    if (op[1]) begin
      exp_w = hit && rdirty[s]; exp_r = 1'b0; exp_waddr = {a[9:4], 4'd0};
    end else begin
      exp_w = !hit && rvld[s] && rdirty[s]; exp_r = !hit;
      exp_waddr = {rtag[s], s, 4'd0};
    end
    wr_cnt = 0; rd_cnt = 0;
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!(rsp_valid || clean_done) && cyc < 60) begin
      chk("R8 ready low while busy", req_ready, 1'b0);
      @(negedge clk);
      cyc++;
    end
    chk("R9 response arrived", cyc < 60, 1'b1);
    if (op[1]) begin
      chk("R9 clean_done on clean", clean_done, 1'b1);
      chk("R9 no rsp on clean", rsp_valid, 1'b0);
    end else begin
      chk("R9 rsp_valid on load/store", rsp_valid, 1'b1);
      chk("R9 no done on load/store", clean_done, 1'b0);
      if (op == 2'b00) chk("R1 load data", rsp_rdata, arch[a[9:2]]);
    end
    if (!exp_w && !exp_r) chk("R3 R8 next-cycle completion", cyc, 0);
    chk(op[1] ? "R2 R3 R6 write count" : "R7 write count", wr_cnt, exp_w);
    chk(op[1] ? "R3 R4 read count" : "R7 read count", rd_cnt, exp_r);
    if (exp_w && wr_cnt == 1) begin
      chk("R5 write address", last_waddr, exp_waddr);
      chk("R2 written line", last_wdata, arch_line(exp_waddr[9:4]));
    end
    if (op == 2'b01) arch[a[9:2]] = d;
    if (op[1]) begin
      if (hit) rdirty[s] = 1'b0;
    end else begin
      if (!hit) begin rvld[s] = 1'b1; rtag[s] = t; rdirty[s] = 1'b0; end
      if (op == 2'b01) rdirty[s] = 1'b1;
    end
    @(negedge clk);
    chk("R9 single-cycle pulse", {rsp_valid, clean_done}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    compared = 0; mismatched = 0; wr_cnt = 0; rd_cnt = 0;
    last_waddr = '0; last_wdata = '0;
    rvld = '0; rdirty = '0;
    for (int i = 0; i < 4; i++) rtag[i] = '0;
    for (int l = 0; l < 64; l++) begin
      for (int w = 0; w < 4; w++) arch[l*4+w] = 32'hA000_0000 | (l << 8) | w;
      bmem[l] = {arch[l*4+3], arch[l*4+2], arch[l*4+1], arch[l*4]};
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 req_ready", req_ready, 1'b1);
    chk("R10 rsp_valid", rsp_valid, 1'b0);
    chk("R10 clean_done", clean_done, 1'b0);
    chk("R10 mem_valid", mem_valid, 1'b0);

    run_op(2'b10, 10'h000, 0);            // R3 clean miss
    run_op(2'b00, 10'h000, 0);            // R1 R7 fill
    run_op(2'b10, 10'h00C, 0);            // R3 clean on clean line
    run_op(2'b01, 10'h004, 32'h1111_2222); // R7 store hit
    run_op(2'b01, 10'h00B, 32'h3333_4444);
    run_op(2'b10, 10'h00F, 0);            // R2 R5 clean dirty, unaligned
    run_op(2'b00, 10'h008, 0);            // R4 hit after clean
    run_op(2'b11, 10'h001, 0);            // R3 second clean: no write
    run_op(2'b00, 10'h040, 0);            // R6 eviction without write-back
    run_op(2'b01, 10'h050, 32'h5555_6666);
    run_op(2'b00, 10'h3D4, 0);            // R7 dirty eviction then fill
    run_op(2'b00, 10'h050, 0);            // R1 stored value from memory
    for (int o = 0; o < 16; o++) begin    // R5 every byte offset
      run_op(2'b01, 10'h120 | ((o * 4) & 12), 32'hC0DE_0000 | o);
      run_op(2'b10, 10'h120 | o, 0);
      run_op(2'b00, 10'h120 | (o & 12), 0);
    end
    lf = 16'hACE1;
    for (int n = 0; n < 500; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run_op(lf[9:8], {2'b00, lf[7:0]} | (lf[15] ? 10'h200 : 10'h000), {lf, n[15:0]});
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule